// File: doc/BRIEF.md
# Saturating 40-bit Accumulator Adder

This block is the add stage of a DSP data path whose accumulators are 40 bits wide: a 32-bit word plus eight guard bits above it. It accepts either two 40-bit register operands, or one register operand plus a 5-bit unsigned immediate. The immediate is zero-extended to 40 bits. In the immediate form the register operand is the destination's current value, and the sum is written back to that destination.

Alongside the sum it produces three flags. The carry flag and the per-destination limit bit are rewritten on every add. The overflow flag is sticky: once set, it stays set until an explicit clear. A saturation-mode input clamps results to the signed 32-bit range. A 2-bit scaling field chooses which upper result bits the limit test examines.

All arithmetic is combinational. Results and flags are registered on a cycle in which `add_en_i` is high. When `add_en_i` is low, they hold.

Top module: `acc40_sat_adder`

## Requirements
- R1: Register form (`imm_sel_i`=0): when saturation mode is off, `sum_o` equals `src_a_i + src_b_i` modulo 2^40.
- R2: Immediate form (`imm_sel_i`=1): the 5-bit `imm_i` (0 to 31) is right-aligned with zeros above it, added to `src_a_i`, and `src_b_i` is ignored.
- R3: `carry_o` is the carry out of bit 39 of the unsigned 40-bit addition of the two formed operands, rewritten on every add.
- R4: A 40-bit overflow occurs when both operands have the same bit 39 and the raw sum's bit 39 differs. It sets `ovf_o`. With saturation off, the result wraps modulo 2^40.
- R5: With `sat_mode_i`=1, a result whose bits 39..31 are not all equal, or whose addition overflowed 40 bits, is clamped. The clamp is to 0x00_7FFF_FFFF when the true sum is positive and to 0xFF_8000_0000 when it is negative, and `ovf_o` is set. A result that is already in range passes through unchanged.
- R6: With `sat_mode_i`=1, `limit_o` is written as 0.
- R7: With saturation off, `limit_o`=1 when the examined result bits are not all equal to bit 39. The examined bits depend on `scale_i`: 00 examines 39..31, 01 examines 39..32, 10 examines 39..30, and 11 behaves as 00.
- R8: `ovf_o` is sticky and is cleared only by `ovf_clr_i`. If a clear and a new overflow event occur in the same cycle, the flag ends up set.
- R9: `sum_o`, `carry_o`, `limit_o` and `sum_vld_o` change one clock after an add. When `add_en_i` is low, `sum_o`, `carry_o` and `limit_o` hold their values and `sum_vld_o` reads 0.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_en_i | input | 1 | Perform an add this cycle |
| imm_sel_i | input | 1 | 1 selects the immediate form |
| imm_i | input | 5 | Unsigned immediate |
| src_a_i | input | 40 | Register operand A, or the destination value in the immediate form |
| src_b_i | input | 40 | Register operand B |
| sat_mode_i | input | 1 | Clamp to the signed 32-bit range |
| scale_i | input | 2 | Scaling mode for the limit test |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| sum_o | output | 40 | Registered result |
| sum_vld_o | output | 1 | Result registered last cycle |
| carry_o | output | 1 | Carry flag |
| limit_o | output | 1 | Limit bit for the destination |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Several behaviours are checked on every cycle:
- a saturated result always lies in the 32-bit range;
- saturation mode always writes a zero limit bit;
- a 40-bit overflow without saturation always flips the sign relative to operand A;
- the overflow flag never drops without a clear and is always set after an overflow event;
- outputs hold when no add is requested.

Only the directed scenarios can confirm the exact arithmetic values: the sums, the zero extension of the immediate, and the carry values. The same holds for the scaling-dependent limit boundaries at 2^30, 2^31 and 2^32, and for the priority of a set over a clear in the same cycle.

// File: rtl/acc40_pkg.sv
package acc40_pkg;
  localparam int DEF_ACC_W  = 40;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_IMM_W  = 5;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;
endpackage

// File: rtl/acc_operand_mux.sv
module acc_operand_mux #(
  parameter int ACC_W = acc40_pkg::DEF_ACC_W,
  parameter int IMM_W = acc40_pkg::DEF_IMM_W
) (
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [ACC_W-1:0] reg_b,
  output logic [ACC_W-1:0] opnd_b
);
  localparam int PAD_W = ACC_W - IMM_W;

  function automatic logic [ACC_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  assign opnd_b = imm_sel ? zext_imm(imm) : reg_b;
endmodule

// File: rtl/acc_add_core.sv
module acc_add_core #(
  parameter int ACC_W = acc40_pkg::DEF_ACC_W
) (
  input  logic [ACC_W-1:0] opnd_a,
  input  logic [ACC_W-1:0] opnd_b,
  output logic [ACC_W-1:0] raw_sum,
  output logic             carry_out,
  output logic             wrap_ovf
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W:0] wide;

  function automatic logic [ACC_W:0] uadd(input logic [ACC_W-1:0] x,
                                          input logic [ACC_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  always_comb begin
    wide      = uadd(opnd_a, opnd_b);
    raw_sum   = wide[ACC_W-1:0];
    carry_out = wide[ACC_W];
    wrap_ovf  = (opnd_a[MSB] == opnd_b[MSB]) && (raw_sum[MSB] != opnd_a[MSB]);
  end
endmodule

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp #(
  parameter int ACC_W  = acc40_pkg::DEF_ACC_W,
  parameter int WORD_W = acc40_pkg::DEF_WORD_W
) (
  input  logic [ACC_W-1:0] raw_sum,
  input  logic             wrap_ovf,
  input  logic             a_sign,
  input  logic             sat_en,
  output logic [ACC_W-1:0] clamped,
  output logic             sat_hit
);
  localparam int MSB = ACC_W - 1;
  localparam int LO  = WORD_W - 1;
  localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  function automatic logic upper_uniform(input logic [ACC_W-1:0] v);
    return (&v[MSB:LO]) | ~(|v[MSB:LO]);
  endfunction

  logic true_neg;
  logic need_clamp;

  always_comb begin
    true_neg   = wrap_ovf ? a_sign : raw_sum[MSB];
    need_clamp = wrap_ovf | ~upper_uniform(raw_sum);
    sat_hit    = sat_en & need_clamp;
    clamped    = sat_hit ? (true_neg ? NEG_LIM : POS_LIM) : raw_sum;
  end
endmodule

// File: rtl/acc_limit_detect.sv
module acc_limit_detect #(
  parameter int ACC_W  = acc40_pkg::DEF_ACC_W,
  parameter int WORD_W = acc40_pkg::DEF_WORD_W
) (
  input  logic [ACC_W-1:0] value,
  input  logic [1:0]       scale,
  input  logic             sat_en,
  output logic             limit
);
  import acc40_pkg::*;

  localparam int MSB = ACC_W - 1;

  function automatic logic outside(input logic [ACC_W-1:0] v, input int lo);
    logic m;
    m = 1'b0;
    for (int i = 0; i < MSB; i++) begin
      if (i >= lo && v[i] != v[MSB]) m = 1'b1;
    end
    return m;
  endfunction

  int lo_bit;

  always_comb begin
    case (scale_e'(scale))
      SCL_DOWN: lo_bit = WORD_W;
      SCL_UP:   lo_bit = WORD_W - 2;
      default:  lo_bit = WORD_W - 1;
    endcase
    limit = sat_en ? 1'b0 : outside(value, lo_bit);
  end
endmodule

// File: rtl/acc40_sat_adder.sv
module acc40_sat_adder #(
  parameter int ACC_W  = acc40_pkg::DEF_ACC_W,
  parameter int WORD_W = acc40_pkg::DEF_WORD_W,
  parameter int IMM_W  = acc40_pkg::DEF_IMM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en_i,
  input  logic             imm_sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ACC_W-1:0] src_a_i,
  input  logic [ACC_W-1:0] src_b_i,
  input  logic             sat_mode_i,
  input  logic [1:0]       scale_i,
  input  logic             ovf_clr_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             sum_vld_o,
  output logic             carry_o,
  output logic             limit_o,
  output logic             ovf_o
);
  logic [ACC_W-1:0] opnd_b;
  logic [ACC_W-1:0] raw_sum;
  logic [ACC_W-1:0] clamped;
  logic             carry_nx;
  logic             wrap_ovf;
  logic             sat_hit;
  logic             limit_nx;
  logic             ovf_evt;

  acc_operand_mux #(.ACC_W(ACC_W), .IMM_W(IMM_W)) u_mux (
    .imm_sel (imm_sel_i),
    .imm     (imm_i),
    .reg_b   (src_b_i),
    .opnd_b  (opnd_b)
  );

  acc_add_core #(.ACC_W(ACC_W)) u_add (
    .opnd_a    (src_a_i),
    .opnd_b    (opnd_b),
    .raw_sum   (raw_sum),
    .carry_out (carry_nx),
    .wrap_ovf  (wrap_ovf)
  );

  acc_sat_clamp #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_sat (
    .raw_sum  (raw_sum),
    .wrap_ovf (wrap_ovf),
    .a_sign   (src_a_i[ACC_W-1]),
    .sat_en   (sat_mode_i),
    .clamped  (clamped),
    .sat_hit  (sat_hit)
  );

  acc_limit_detect #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_lim (
    .value  (clamped),
    .scale  (scale_i),
    .sat_en (sat_mode_i),
    .limit  (limit_nx)
  );

  assign ovf_evt = add_en_i & (wrap_ovf | sat_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o     <= '0;
      sum_vld_o <= 1'b0;
      carry_o   <= 1'b0;
      limit_o   <= 1'b0;
    end else begin
      sum_vld_o <= add_en_i;
      if (add_en_i) begin
        sum_o   <= clamped;
        carry_o <= carry_nx;
        limit_o <= limit_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_o <= 1'b0;
    else if (ovf_evt)   ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end
endmodule

// File: rtl/acc40_sat_adder_chk.sv
module acc40_sat_adder_chk #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             add_en_i,
  input logic             sat_mode_i,
  input logic             ovf_clr_i,
  input logic [ACC_W-1:0] src_a_i,
  input logic             wrap_ovf,
  input logic             ovf_evt,
  input logic [ACC_W-1:0] sum_o,
  input logic             sum_vld_o,
  input logic             carry_o,
  input logic             limit_o,
  input logic             ovf_o
);
  localparam int UPN = ACC_W - WORD_W + 1;

  assert_sat_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    add_en_i && sat_mode_i |=> ($countones(sum_o[ACC_W-1:WORD_W-1]) == 0 ||
                                $countones(sum_o[ACC_W-1:WORD_W-1]) == UPN));

  assert_sat_clears_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    add_en_i && sat_mode_i |=> !limit_o);

  assert_wrap_flips_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    add_en_i && wrap_ovf && !sat_mode_i |=> sum_o[ACC_W-1] != $past(src_a_i[ACC_W-1]));

  assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_o);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr_i && !ovf_evt |=> !ovf_o);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en_i |=> $stable(sum_o) && $stable(carry_o) && $stable(limit_o) && !sum_vld_o);
endmodule

bind acc40_sat_adder acc40_sat_adder_chk #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .add_en_i   (add_en_i),
  .sat_mode_i (sat_mode_i),
  .ovf_clr_i  (ovf_clr_i),
  .src_a_i    (src_a_i),
  .wrap_ovf   (wrap_ovf),
  .ovf_evt    (ovf_evt),
  .sum_o      (sum_o),
  .sum_vld_o  (sum_vld_o),
  .carry_o    (carry_o),
  .limit_o    (limit_o),
  .ovf_o      (ovf_o)
);

// File: tb/acc40_sat_adder_test.sv
module acc40_sat_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        add_en_i = 1'b0;
  logic        imm_sel_i = 1'b0;
  logic [4:0]  imm_i = '0;
  logic [39:0] src_a_i = '0;
  logic [39:0] src_b_i = '0;
  logic        sat_mode_i = 1'b0;
  logic [1:0]  scale_i = 2'b00;
  logic        ovf_clr_i = 1'b0;
  logic [39:0] sum_o;
  logic        sum_vld_o, carry_o, limit_o, ovf_o;

  int checks = 0;
  int fails = 0;
  logic exp_ovf = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  acc40_sat_adder uut (
    .clk(clk), .rst_n(rst_n), .add_en_i(add_en_i), .imm_sel_i(imm_sel_i),
    .imm_i(imm_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .sat_mode_i(sat_mode_i),
    .scale_i(scale_i), .ovf_clr_i(ovf_clr_i), .sum_o(sum_o), .sum_vld_o(sum_vld_o),
    .carry_o(carry_o), .limit_o(limit_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // Bench model: signed integer arithmetic rather than bit slicing
  function automatic longint sx(input logic [39:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic in_range(input longint v, input int k);
    longint hi = (longint'(1) << k) - 1;
    return (v <= hi) && (v >= -hi - 1);
  endfunction

  task automatic do_add(input string tag, input logic isel, input logic [4:0] im,
                        input logic [39:0] a, input logic [39:0] b,
                        input logic sat, input logic [1:0] scl, input logic clr);
    logic [39:0] bop;
    longint ts;
    logic [40:0] us;
    logic [39:0] er;
    logic ec, el, evt, ovf40;
    int k;
    bop = isel ? {35'd0, im} : b;
    ts  = sx(a) + sx(bop);
    us  = {1'b0, a} + {1'b0, bop};
    ec  = us[40];
    ovf40 = !in_range(ts, 39);
    er  = us[39:0];
    evt = ovf40;
    if (sat && !in_range(ts, 31)) begin
      er  = (ts > 0) ? 40'h00_7FFF_FFFF : 40'hFF_8000_0000;
      evt = 1'b1;
    end
    k = (scl == 2'b01) ? 32 : (scl == 2'b10) ? 30 : 31;
    el = sat ? 1'b0 : !in_range(sx(er), k);
    if (evt) exp_ovf = 1'b1;
    else if (clr) exp_ovf = 1'b0;

    @(negedge clk);
    add_en_i = 1'b1; imm_sel_i = isel; imm_i = im; src_a_i = a; src_b_i = b;
    sat_mode_i = sat; scale_i = scl; ovf_clr_i = clr;
    @(negedge clk);
    add_en_i = 1'b0; ovf_clr_i = 1'b0;
    chk(tag, "sum", sum_o, er);
    chk("R3", "carry", {39'd0, carry_o}, {39'd0, ec});
    chk(sat ? "R6" : "R7", "limit", {39'd0, limit_o}, {39'd0, el});
    chk(tag, "ovf", {39'd0, ovf_o}, {39'd0, exp_ovf});
    chk("R9", "valid", {39'd0, sum_vld_o}, 40'd1);
  endtask

  task automatic t_reset();
    chk("R10", "sum", sum_o, '0);
    chk("R10", "flags", {36'd0, sum_vld_o, carry_o, limit_o, ovf_o}, '0);
  endtask

  task automatic t_reg_form();
    do_add("R1", 0, 5'd0, 40'h00_0000_0005, 40'h00_0000_0002, 0, 2'b00, 0);
    do_add("R1", 0, 5'd0, 40'hFF_FFFF_FFFB, 40'h00_0000_0003, 0, 2'b00, 0);
    do_add("R3", 0, 5'd0, 40'hFF_FFFF_FFFF, 40'h00_0000_0001, 0, 2'b00, 0);
  endtask

  task automatic t_imm_form();
    do_add("R2", 1, 5'd31, 40'h00_0000_1000, 40'hFF_FFFF_FFFF, 0, 2'b00, 0);
    do_add("R2", 1, 5'd0, 40'h12_3456_789A, 40'h00_0000_7777, 0, 2'b00, 0);
    do_add("R2", 1, 5'd1, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 0, 2'b00, 0);
  endtask

  task automatic t_wrap();
    do_add("R4", 0, 5'd0, 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 0, 2'b00, 0);
    do_add("R8", 0, 5'd0, 40'h00_0000_0001, 40'h00_0000_0001, 0, 2'b00, 0);
    do_add("R8", 0, 5'd0, 40'h00_0000_0001, 40'h00_0000_0001, 0, 2'b00, 1);
    do_add("R4", 0, 5'd0, 40'h80_0000_0000, 40'hFF_FFFF_FFFF, 0, 2'b00, 0);
    do_add("R8", 0, 5'd0, 40'h80_0000_0000, 40'h80_0000_0000, 0, 2'b00, 1);
  endtask

  task automatic t_clear_idle();
    @(negedge clk);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    exp_ovf = 1'b0;
    chk("R8", "ovf after clear", {39'd0, ovf_o}, 40'd0);
  endtask

  task automatic t_saturate();
    do_add("R5", 0, 5'd0, 40'h00_7FFF_FFFF, 40'h00_0000_0001, 1, 2'b00, 0);
    t_clear_idle();
    do_add("R5", 0, 5'd0, 40'hFF_8000_0000, 40'hFF_FFFF_FFFF, 1, 2'b00, 0);
    t_clear_idle();
    do_add("R5", 0, 5'd0, 40'h7F_0000_0000, 40'h7F_0000_0000, 1, 2'b01, 0);
    t_clear_idle();
    do_add("R5", 0, 5'd0, 40'h80_0000_0000, 40'h80_0000_0000, 1, 2'b00, 0);
    t_clear_idle();
    do_add("R6", 0, 5'd0, 40'h00_1234_0000, 40'h00_0000_5678, 1, 2'b10, 0);
  endtask

  task automatic t_scaling();
    for (int s = 0; s < 4; s++) begin
      do_add("R7", 0, 5'd0, 40'h00_7FFF_FFFF, 40'h00_0000_0001, 0, 2'(s), 0);
      do_add("R7", 0, 5'd0, 40'h00_3FFF_FFFF, 40'h00_0000_0001, 0, 2'(s), 0);
      do_add("R7", 0, 5'd0, 40'h00_FFFF_FFFF, 40'h00_0000_0001, 0, 2'(s), 0);
      do_add("R7", 0, 5'd0, 40'hFF_C000_0000, 40'hFF_FFFF_FFFF, 0, 2'(s), 0);
    end
  endtask

  task automatic t_hold();
    logic [39:0] keep_s;
    logic keep_c, keep_l;
    do_add("R9", 0, 5'd0, 40'hFF_FFFF_FFFF, 40'h00_8000_0000, 0, 2'b00, 0);
    keep_s = sum_o; keep_c = carry_o; keep_l = limit_o;
    @(negedge clk);
    src_a_i = 40'h7F_FFFF_FFFF; src_b_i = 40'h7F_FFFF_FFFF; sat_mode_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "held sum", sum_o, keep_s);
    chk("R9", "held flags", {38'd0, carry_o, limit_o}, {38'd0, keep_c, keep_l});
    chk("R9", "valid low", {39'd0, sum_vld_o}, 40'd0);
    chk("R9", "ovf unchanged", {39'd0, ovf_o}, {39'd0, exp_ovf});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reg_form();
    t_imm_form();
    t_wrap();
    t_clear_idle();
    t_saturate();
    t_scaling();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule